// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block times the external memory bus cycles of one chip-select region. When a cycle is requested, it latches the 4-bit wait code that belongs to the cycle's direction. Read cycles and write cycles each have their own code. The block then holds `busy` for the required number of clock states and marks the last state with a one-clock `cycleDone` pulse.

A code can select a fixed cycle length. The fixed lengths are not linear: every length from 2 to 12 states is available, and above that only 14, 18 and 22 states. One code instead hands the end of the cycle to an active-low wait input. In that mode the cycle lasts at least six states and then stretches for as long as the synchronised wait input is seen low.

Some regions are handled by a separate protocol engine rather than by this timing. For those regions a request only produces a one-clock `bypass` pulse.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset `busy`, `cycleDone` and `bypass` are low.
- R2: Codes 0 to 10 (binary 0000 to 1010) give a cycle of code+2 states, so code 0 gives exactly 2 states. A cycle of N states keeps `busy` high for N clocks, starting the clock after the start request is sampled.
- R3: Code 11 (1011) gives 14 states, code 12 (1100) gives 18 states and code 13 (1101) gives 22 states.
- R4: A cycle with `isWrite`=1 takes its code from `wrCfg`. A cycle with `isWrite`=0 takes its code from `rdCfg`.
- R5: The reserved code 15 (1111) gives the default cycle of 3 states.
- R6: Code 14 (1110) selects wait-pin mode. If `waitN` stays high, the cycle is exactly 6 states long.
- R7: In wait-pin mode, `waitN` passes through a two-flip-flop synchroniser. Suppose `waitN` rises during state s while low before it. The cycle then ends in state max(6, s+2).
- R8: The selected code is captured when the cycle starts. Changing `rdCfg` or `wrCfg` during a cycle does not change that cycle's length.
- R9: A start request with `regionUntimed`=1 raises `bypass` for exactly the next clock. It never raises `busy` or `cycleDone`.
- R10: `cycleDone` is high for one clock, in the final state of a cycle, and `busy` falls on the following clock. A start request made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to begin a bus cycle |
| isWrite | input | 1 | Direction of the requested cycle (1 = write) |
| rdCfg | input | 4 | Wait code used by read cycles |
| wrCfg | input | 4 | Wait code used by write cycles |
| regionUntimed | input | 1 | Region is served by an external protocol engine |
| waitN | input | 1 | Asynchronous active-low wait input |
| busy | output | 1 | A bus cycle is in progress |
| cycleDone | output | 1 | One-clock pulse in the final state |
| bypass | output | 1 | One-clock pulse when a request is handed off |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser and a six-state minimum for wait-pin mode. With these values, the exact end state of a stretched cycle can be predicted as release state plus two. This lets the bench test both the six-state floor and the extension beyond it. Every fixed code, including the three non-linear long lengths and the reserved code, is measured in clocks of `busy`.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int CODE_W  = 4;
  localparam int STATE_W = 5;

  typedef struct packed {
    logic loadCfg;
    logic countUp;
  } dpStrobe_t;

  typedef struct packed {
    logic               pinMode;
    logic [STATE_W-1:0] states;
  } waitDecode_t;

  function automatic waitDecode_t decodeWait(input logic [CODE_W-1:0] code);
    waitDecode_t d;
    d.pinMode = 1'b0;
    if (code <= 4'd10)       d.states = STATE_W'(code) + STATE_W'(2);
    else if (code == 4'd11)  d.states = STATE_W'(14);
    else if (code == 4'd12)  d.states = STATE_W'(18);
    else if (code == 4'd13)  d.states = STATE_W'(22);
    else if (code == 4'd14) begin
      d.pinMode = 1'b1;
      d.states  = STATE_W'(6);
    end else                 d.states = STATE_W'(3);
    return d;
  endfunction
endpackage

// File: rtl/bwc_datapath.sv
module bwc_datapath
  import bwc_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int PIN_MIN_STATES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strb,
  input  logic              isWrite,
  input  logic [CODE_W-1:0] rdCfg,
  input  logic [CODE_W-1:0] wrCfg,
  input  logic              waitN,
  output logic              endNow
);
  localparam logic [STATE_W-1:0] PIN_MIN = STATE_W'(PIN_MIN_STATES);
  localparam logic [STATE_W-1:0] CNT_MAX = '1;

  logic [CODE_W-1:0]      selCode;
  waitDecode_t            dec;
  logic [STATE_W-1:0]     targetQ;
  logic [STATE_W-1:0]     cntQ;
  logic                   pinModeQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   waitInactive;

  assign selCode = isWrite ? wrCfg : rdCfg;
  assign dec     = decodeWait(selCode);

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) syncQ <= '1;
        else        syncQ <= waitN;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) syncQ <= '1;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], waitN};
    end
  endgenerate

  assign waitInactive = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      targetQ  <= STATE_W'(3);
      pinModeQ <= 1'b0;
      cntQ     <= '0;
    end else if (strb.loadCfg) begin
      targetQ  <= dec.states;
      pinModeQ <= dec.pinMode;
      cntQ     <= STATE_W'(1);
    end else if (strb.countUp && cntQ != CNT_MAX) begin
      cntQ <= cntQ + STATE_W'(1);
    end
  end

  assign endNow = pinModeQ ? (cntQ >= PIN_MIN && waitInactive)
                           : (cntQ == targetQ);
endmodule

// File: rtl/bwc_control.sv
module bwc_control
  import bwc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      startReq,
  input  logic      regionUntimed,
  input  logic      endNow,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      cycleDone,
  output logic      bypass
);
  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;

  ctlState_t stateQ, stateNxt;
  logic      bypassQ, bypassNxt;

  always_comb begin
    strb      = '0;
    cycleDone = 1'b0;
    bypassNxt = 1'b0;
    stateNxt  = stateQ;
    unique case (stateQ)
      ST_IDLE: if (startReq) begin
        if (regionUntimed) bypassNxt = 1'b1;
        else begin
          strb.loadCfg = 1'b1;
          stateNxt     = ST_RUN;
        end
      end
      ST_RUN: if (endNow) begin
        cycleDone = 1'b1;
        stateNxt  = ST_IDLE;
      end else begin
        strb.countUp = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= ST_IDLE;
      bypassQ <= 1'b0;
    end else begin
      stateQ  <= stateNxt;
      bypassQ <= bypassNxt;
    end
  end

  assign busy   = (stateQ == ST_RUN);
  assign bypass = bypassQ;
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int PIN_MIN_STATES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       isWrite,
  input  logic [3:0] rdCfg,
  input  logic [3:0] wrCfg,
  input  logic       regionUntimed,
  input  logic       waitN,
  output logic       busy,
  output logic       cycleDone,
  output logic       bypass
);
  dpStrobe_t strb;
  logic      endNow;

  bwc_control u_ctl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq),
    .regionUntimed(regionUntimed), .endNow(endNow), .strb(strb),
    .busy(busy), .cycleDone(cycleDone), .bypass(bypass)
  );

  bwc_datapath #(.SYNC_STAGES(SYNC_STAGES), .PIN_MIN_STATES(PIN_MIN_STATES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .isWrite(isWrite),
    .rdCfg(rdCfg), .wrCfg(wrCfg), .waitN(waitN), .endNow(endNow)
  );
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker (
  input logic clk,
  input logic rst_n,
  input logic startReq,
  input logic regionUntimed,
  input logic busy,
  input logic cycleDone,
  input logic bypass
);
  logic [7:0] runLen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 runLen <= '0;
    else if (busy && cycleDone) runLen <= '0;
    else if (busy && runLen != 8'hFF) runLen <= runLen + 8'd1;

  AST_DONE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cycleDone |-> busy);                                         // R10
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cycleDone |=> !busy);                                        // R10
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cycleDone) |=> busy);                              // R10
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq && !regionUntimed) |=> busy);             // R2
  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (!busy && !cycleDone));                           // R9
  AST_BYPASS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> !bypass);                                         // R9
  AST_MIN_TWO_STATES: assert property (@(posedge clk) disable iff (!rst_n)
    cycleDone |-> runLen >= 8'd1);                               // R2
endmodule

bind bus_wait_ctrl bwc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .startReq(startReq), .regionUntimed(regionUntimed),
  .busy(busy), .cycleDone(cycleDone), .bypass(bypass)
);

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startReq = 1'b0, isWrite = 1'b0, regionUntimed = 1'b0, waitN = 1'b1;
  logic [3:0] rdCfg = 4'd1, wrCfg = 4'd1;
  logic busy, cycleDone, bypass;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  bus_wait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .isWrite(isWrite),
    .rdCfg(rdCfg), .wrCfg(wrCfg), .regionUntimed(regionUntimed),
    .waitN(waitN), .busy(busy), .cycleDone(cycleDone), .bypass(bypass)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts a cycle and returns its length in states; optional waitN release
  // in state relState, optional config change and busy-time start request.
  task automatic runCycle(input bit wr, input int relState, input bit poke,
                          output int len, output int doneCnt);
    int n = 0;
    doneCnt = 0;
    isWrite = wr;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (busy && n < 100) begin
      n++;
      if (cycleDone) doneCnt++;
      if (n == relState) waitN = 1'b1;
      if (poke && n == 2) begin
        rdCfg = 4'd0; wrCfg = 4'd0; startReq = 1'b1;
      end
      if (poke && n == 4) startReq = 1'b0;
      @(negedge clk);
    end
    len = n;
    repeat (3) @(negedge clk);
  endtask

  task automatic fixedCode(input bit wr, input logic [3:0] code, input int exp, input string req);
    int len, dc;
    if (wr) begin wrCfg = code; rdCfg = ~code; end
    else    begin rdCfg = code; wrCfg = ~code; end
    runCycle(wr, 0, 1'b0, len, dc);
    check(len == exp, req, len, exp);
    check(dc == 1, "R10", dc, 1);
  endtask

  task automatic testReset();
    check(!busy && !cycleDone && !bypass, "R1", {busy, cycleDone, bypass}, 0);
  endtask

  task automatic testLinear();
    for (int c = 0; c <= 10; c++) fixedCode(c[0], 4'(c), c + 2, "R2");
  endtask

  task automatic testLong();
    fixedCode(1'b0, 4'd11, 14, "R3");
    fixedCode(1'b1, 4'd12, 18, "R3");
    fixedCode(1'b0, 4'd13, 22, "R3");
  endtask

  task automatic testDirection();
    int len, dc;
    rdCfg = 4'd0; wrCfg = 4'd5;
    runCycle(1'b0, 0, 1'b0, len, dc);
    check(len == 2, "R4 read", len, 2);
    runCycle(1'b1, 0, 1'b0, len, dc);
    check(len == 7, "R4 write", len, 7);
  endtask

  task automatic testReserved();
    fixedCode(1'b0, 4'd15, 3, "R5");
    fixedCode(1'b1, 4'd15, 3, "R5");
  endtask

  task automatic testPinMode();
    int len, dc;
    rdCfg = 4'd14; wrCfg = 4'd14; waitN = 1'b1;
    runCycle(1'b0, 0, 1'b0, len, dc);
    check(len == 6, "R6", len, 6);
    waitN = 1'b0; repeat (3) @(negedge clk);
    runCycle(1'b1, 10, 1'b0, len, dc);
    check(len == 12, "R7 late release", len, 12);
    waitN = 1'b0; repeat (3) @(negedge clk);
    runCycle(1'b0, 2, 1'b0, len, dc);
    check(len == 6, "R7 early release", len, 6);
    waitN = 1'b0; repeat (3) @(negedge clk);
    runCycle(1'b0, 4, 1'b0, len, dc);
    check(len == 6, "R7 release at s4", len, 6);
    waitN = 1'b0; repeat (3) @(negedge clk);
    runCycle(1'b0, 5, 1'b0, len, dc);
    check(len == 7, "R7 release at s5", len, 7);
    waitN = 1'b1;
  endtask

  task automatic testLatchAndIgnore();
    int len, dc;
    rdCfg = 4'd8; wrCfg = 4'd8;
    runCycle(1'b0, 0, 1'b1, len, dc);
    check(len == 10, "R8", len, 10);
    check(dc == 1, "R10 single done", dc, 1);
    check(!busy, "R10 busy start ignored", busy, 0);
  endtask

  task automatic testBypass();
    int seen = 0;
    regionUntimed = 1'b1; rdCfg = 4'd3;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(bypass == 1'b1, "R9 pulse", bypass, 1);
    check(!busy && !cycleDone, "R9 no cycle", {busy, cycleDone}, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bypass || busy || cycleDone) seen++;
    end
    check(seen == 0, "R9 quiet after", seen, 0);
    regionUntimed = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testLinear();
    testLong();
    testDirection();
    testReserved();
    testPinMode();
    testLatchAndIgnore();
    testBypass();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule